// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple host request port and a 32-bit extended-data-out DRAM array made of four byte-wide devices. The devices share one active-low row strobe, and each byte lane has its own active-low column strobe. A word address from the host is split into a row part and a column part, and the two parts are presented one after the other on a narrow multiplexed address bus. Every DRAM timing is a clock-cycle count set by a parameter.

The host raises `req_valid` with an address, a direction, byte enables and write data, and the request is taken on a clock edge where `req_ready` is also high. A read comes back as a one-cycle `rd_valid` pulse carrying `rd_data`. When the next request falls in the row that is already open, the controller keeps the row strobe low and only cycles the column strobes. Any other request closes the row and precharges before the next activation. Writes are always early writes.

Refresh uses the column-before-row form, and the devices' own row counters supply the address. After reset the controller waits out a power-up pause and issues a warm-up burst of refreshes. Only then does it accept host requests. From then on, a refresh timer raises a request at a fixed interval, and that request takes priority over host traffic.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `dram_ras_n`, `dram_we_n` and all four `dram_cas_n` bits are 1, and `dram_dq_oe`, `req_ready` and `rd_valid` are 0.
- R2: After reset is released, no strobe moves during the first PWRUP_CYC cycles. Then exactly 8 refreshes are issued before `req_ready` first rises, and no row activation happens before that.
- R3: A refresh drives all four `dram_cas_n` bits low at least T_CSR cycles before `dram_ras_n` falls, with `dram_we_n` held at 1.
- R4: On a write, `dram_cas_n[i]` falls only when `req_be[i]` is 1, and lane i is data bits 8i+7..8i. When `req_be` is 0, no column strobe falls and the array is left unchanged.
- R5: On a write, `dram_we_n` is 0 for at least one cycle before any column strobe falls, and `dram_dq_oe` is 1 when the strobe falls. On a read, `dram_dq_oe` is 0 and `dram_we_n` is 1.
- R6: Read data is sampled exactly T_CAC cycles after the column strobe falls. It is returned on `rd_data` together with a `rd_valid` pulse that lasts one cycle.
- R7: `dram_addr` carries `req_addr[ROW_W+COL_W-1:COL_W]` when the row strobe falls and `req_addr[COL_W-1:0]` when a column strobe falls.
- R8: A request to the open row that arrives at the end of column precharge is served without a new row activation, as long as no refresh is pending and the row-open limit has not been reached.
- R9: A request to a different row closes the open row, and the row strobe stays high for at least T_RP cycles before the next activation.
- R10: After the warm-up, one refresh is issued for every REF_INT cycles that elapse.
- R11: The row strobe is never held low for more than RAS_LIMIT+T_CAC+T_CP+2 cycles. A long page burst is split into several activations.
- R12: After the row strobe falls, the first column strobe falls at least T_RCD cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row part in the upper bits |
| req_be | input | 4 | Byte enables, bit i selects lane i |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 32 | Read data |
| dram_ras_n | output | 1 | Shared row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_dq_out | output | 32 | Data driven to the array |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 32 | Data returned from the array |

## Verification
The bench fills a small array over every address and every byte-enable pattern, then reads it all back. A design that swapped or shifted the row and column fields would leave the array contents at the wrong indices, and a design with the lanes mapped wrongly would corrupt the other bytes of a word. Page hits and row misses are counted through activations: a design that reopened the row on every access, or kept it open across a row change, would show the wrong count. The bench also watches refresh order and write-enable timing at the strobe edges, and measures the power-up pause, the refresh rate over a long idle period and the longest row-open span, so that a late write enable, a short warm-up or a page that is never closed would each be reported.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_CSET, ST_COL, ST_CPRE, ST_PRE, ST_RCAS, ST_RRAS
  } edo_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_ref_sched.sv
module edo_ref_sched #(
  parameter int PWRUP_CYC = 50000,
  parameter int REF_INT   = 3900,
  parameter int WARM_CNT  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ack,
  output logic ref_pend,
  output logic init_done
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int IW = $clog2(REF_INT + 1);
  localparam int WW = $clog2(WARM_CNT + 1);

  logic [PW-1:0] pw_cnt;
  logic          pw_done;
  logic [IW-1:0] iv_cnt;
  logic          per_flag;
  logic [WW-1:0] warm_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pw_cnt    <= '0;
      pw_done   <= 1'b0;
      iv_cnt    <= '0;
      per_flag  <= 1'b0;
      warm_left <= WW'(WARM_CNT);
    end else if (!pw_done) begin
      pw_cnt <= pw_cnt + 1'b1;
      if (pw_cnt == PW'(PWRUP_CYC - 1)) pw_done <= 1'b1;
    end else begin
      // ack clears first; a timer tick in the same cycle wins
      if (ref_ack) begin
        if (warm_left != '0) warm_left <= warm_left - 1'b1;
        else                 per_flag  <= 1'b0;
      end
      if (iv_cnt == IW'(REF_INT - 1)) begin
        iv_cnt   <= '0;
        per_flag <= 1'b1;
      end else begin
        iv_cnt <= iv_cnt + 1'b1;
      end
    end
  end

  assign ref_pend  = pw_done && ((warm_left != '0) || per_flag);
  assign init_done = pw_done && (warm_left == '0);

  assert_ack_pending_R10: assert property (@(posedge clk) disable iff (rst)
    ref_ack |-> ref_pend);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int LIMIT = 2400,
  parameter int SLACK = 10,
  parameter int AGE_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  output logic [AGE_W-1:0] age,
  output logic             close_req
);
  always_ff @(posedge clk) begin
    if (rst || ras_n)    age <= '0;
    else if (age != '1)  age <= age + 1'b1;
  end

  assign close_req = age >= AGE_W'(LIMIT);

  assert_ras_window_R11: assert property (@(posedge clk) disable iff (rst)
    age <= AGE_W'(LIMIT + SLACK));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int T_RCD  = 6,
  parameter int T_CAC  = 5,
  parameter int T_CP   = 3,
  parameter int T_RP   = 12,
  parameter int T_CSR  = 2,
  parameter int T_RFC  = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES-1:0]       req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                   rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data,
  input  logic                   ref_pend,
  input  logic                   init_done,
  input  logic                   close_req,
  output logic                   ref_ack,
  output logic                   ras_n,
  output logic [LANES-1:0]       cas_n,
  output logic                   we_n,
  output logic [ADDR_W-1:0]      addr,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                   dq_oe,
  input  logic [LANES*LANE_W-1:0] dq_in
);
  localparam int TMAX = imax(imax(imax(T_RCD, T_CAC), imax(T_CP, T_RP)), imax(T_CSR, T_RFC));
  localparam int CW   = $clog2(TMAX + 1) + 1;

  edo_state_t       st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             cur_we;
  logic [LANES-1:0] cur_be;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             idle_take, page_take, accept;

  assign req_row   = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign idle_take = (st == ST_IDLE) && init_done && !ref_pend;
  assign page_take = (st == ST_CPRE) && (cnt == '0) && !ref_pend && !close_req &&
                     (req_row == open_row);
  assign req_ready = idle_take || page_take;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;
      ras_n <= 1'b1;  cas_n <= '1;  we_n <= 1'b1;  addr <= '0;
      dq_out <= '0;   dq_oe <= 1'b0;
      rd_valid <= 1'b0;  rd_data <= '0;  ref_ack <= 1'b0;
      open_row <= '0; col_q <= '0;  cur_we <= 1'b0;  cur_be <= '0;
    end else begin
      rd_valid <= 1'b0;
      ref_ack  <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (accept) begin
        col_q  <= req_col;
        cur_we <= req_we;
        cur_be <= req_be;
        dq_out <= req_wdata;
      end
      case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            cas_n <= '0;  we_n <= 1'b1;  dq_oe <= 1'b0;
            st <= ST_RCAS;  cnt <= CW'(T_CSR - 1);
          end else if (accept) begin
            ras_n <= 1'b0;  addr <= ADDR_W'(req_row);  open_row <= req_row;
            st <= ST_ACT;  cnt <= CW'(T_RCD - 1);
          end
        end
        ST_ACT: if (cnt == '0) begin
          addr <= ADDR_W'(col_q);  we_n <= ~cur_we;  dq_oe <= cur_we;
          st <= ST_CSET;
        end
        ST_CSET: begin
          cas_n <= ~cur_be;
          st <= ST_COL;  cnt <= CW'(T_CAC - 1);
        end
        ST_COL: if (cnt == '0) begin
          cas_n <= '1;
          if (!cur_we) begin
            rd_valid <= 1'b1;
            rd_data  <= dq_in;
          end
          st <= ST_CPRE;  cnt <= CW'(T_CP - 1);
        end
        ST_CPRE: if (cnt == '0) begin
          if (accept) begin
            addr <= ADDR_W'(req_col);  we_n <= ~req_we;  dq_oe <= req_we;
            st <= ST_CSET;
          end else begin
            ras_n <= 1'b1;  we_n <= 1'b1;  dq_oe <= 1'b0;
            st <= ST_PRE;  cnt <= CW'(T_RP - 1);
          end
        end
        ST_PRE: if (cnt == '0) st <= ST_IDLE;
        ST_RCAS: if (cnt == '0) begin
          ras_n <= 1'b0;  ref_ack <= 1'b1;
          st <= ST_RRAS;  cnt <= CW'(T_RFC - 1);
        end
        ST_RRAS: if (cnt == '0) begin
          ras_n <= 1'b1;  cas_n <= '1;
          st <= ST_PRE;  cnt <= CW'(T_RP - 1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_act_after_init_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cas_n == '1) |-> init_done);
  assert_cbr_form_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cas_n == '0) |-> (we_n && $past(cas_n) == '0));
  assert_early_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(cas_n) == '1 && cas_n != '1 && !we_n) |-> !$past(we_n));
  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 11,
  parameter int T_RCD     = 6,
  parameter int T_CAC     = 5,
  parameter int T_CP      = 3,
  parameter int T_RP      = 12,
  parameter int T_CSR     = 2,
  parameter int T_RFC     = 15,
  parameter int PWRUP_CYC = 50000,
  parameter int REF_INT   = 3900,
  parameter int RAS_LIMIT = 2400
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  output logic                   dram_ras_n,
  output logic [3:0]             dram_cas_n,
  output logic                   dram_we_n,
  output logic [ADDR_W-1:0]      dram_addr,
  output logic [31:0]            dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [31:0]            dram_dq_in
);
  localparam int SLACK = T_CAC + T_CP + 2;
  localparam int AGE_W = $clog2(RAS_LIMIT + SLACK + 2) + 1;

  logic             ref_pend, init_done, ref_ack, close_req;
  logic [AGE_W-1:0] ras_age;

  edo_ref_sched #(.PWRUP_CYC(PWRUP_CYC), .REF_INT(REF_INT), .WARM_CNT(8)) u_sched (
    .clk(clk), .rst(rst), .ref_ack(ref_ack), .ref_pend(ref_pend), .init_done(init_done));

  edo_ras_guard #(.LIMIT(RAS_LIMIT), .SLACK(SLACK), .AGE_W(AGE_W)) u_guard (
    .clk(clk), .rst(rst), .ras_n(dram_ras_n), .age(ras_age), .close_req(close_req));

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .LANES(4), .LANE_W(8),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFC(T_RFC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_pend(ref_pend), .init_done(init_done), .close_req(close_req), .ref_ack(ref_ack),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .addr(dram_addr),
    .dq_out(dram_dq_out), .dq_oe(dram_dq_oe), .dq_in(dram_dq_in));

  assert_rcd_R12: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && $past(dram_cas_n) == 4'hF && dram_cas_n != 4'hF) |->
      ras_age >= AGE_W'(T_RCD));
endmodule

// File: tb/sim_edo_dram_ctrl.sv
`timescale 1ns/1ps
module sim_edo_dram_ctrl;
  localparam int ROW_W = 3, COL_W = 3, ADDR_W = 4;
  localparam int T_RCD = 2, T_CAC = 2, T_CP = 1, T_RP = 2, T_CSR = 1, T_RFC = 2;
  localparam int PWRUP = 100, REF_INT = 300, RAS_LIMIT = 40;
  localparam int NW = 1 << (ROW_W + COL_W);
  localparam int NCOL = 1 << COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_we_n, dram_dq_oe;
  logic [31:0] rd_data, dram_dq_out, dram_dq_in;
  logic [3:0] dram_cas_n;
  logic [ADDR_W-1:0] dram_addr;

  always #2 clk = ~clk;

  edo_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_CAC(T_CAC),
    .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFC(T_RFC), .PWRUP_CYC(PWRUP),
    .REF_INT(REF_INT), .RAS_LIMIT(RAS_LIMIT)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // array model and strobe monitor
  logic [31:0] mem [NW];
  logic [31:0] shadow [NW];
  logic [31:0] rd_log [256];
  int rd_lat [256];
  int rd_n = 0;
  int cyc = 0, m_row = 0, m_col = 0;
  int ras_fall_t = 0, ras_rise_t = -1000, cas_low_age = 0, first_ref_t = -1;
  int span_max = 0, pre_min = 1000, rcd_min = 1000, last_rd_t = 0;
  int ref_cnt = 0, act_cnt = 0, bad_cbr = 0, bad_ew = 0, bad_oe = 0;
  bit fresh = 0;
  logic p_ras = 1'b1, p_we = 1'b1;
  logic [3:0] p_cas = 4'hF;

  always_comb begin
    for (int l = 0; l < 4; l++)
      dram_dq_in[l*8 +: 8] = !dram_cas_n[l] ? mem[m_row*NCOL + m_col][l*8 +: 8] : 8'h00;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_ras && !dram_ras_n) begin
        if (dram_cas_n == 4'h0) begin
          ref_cnt++;
          if (first_ref_t < 0) first_ref_t = cyc;
          if (!dram_we_n || cas_low_age < T_CSR) bad_cbr++;
        end else begin
          act_cnt++;
          m_row = int'(dram_addr[ROW_W-1:0]);
          fresh = 1;
        end
        if (cyc - ras_rise_t < pre_min) pre_min = cyc - ras_rise_t;
        ras_fall_t = cyc;
      end
      if (!p_ras && dram_ras_n) begin
        ras_rise_t = cyc;
        if (cyc - ras_fall_t > span_max) span_max = cyc - ras_fall_t;
      end
      if (p_cas == 4'hF && dram_cas_n != 4'hF && !dram_ras_n) begin
        m_col = int'(dram_addr[COL_W-1:0]);
        if (fresh && cyc - ras_fall_t < rcd_min) rcd_min = cyc - ras_fall_t;
        fresh = 0;
        if (!dram_we_n) begin
          if (p_we || !dram_dq_oe) bad_ew++;
          for (int l = 0; l < 4; l++)
            if (!dram_cas_n[l]) mem[m_row*NCOL + m_col][l*8 +: 8] = dram_dq_out[l*8 +: 8];
        end else begin
          last_rd_t = cyc;
          if (dram_dq_oe) bad_oe++;
        end
      end
      if (rd_valid) begin
        rd_log[rd_n] = rd_data;
        rd_lat[rd_n] = cyc - last_rd_t;
        rd_n++;
      end
      cas_low_age = (dram_cas_n == 4'h0) ? cas_low_age + 1 : 0;
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
  end

  task automatic xfer(input bit we, input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_we = we; req_addr = (ROW_W+COL_W)'(a); req_be = be; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'hA500_0000 ^ (32'(a) << 16) ^ (32'(a * 7) << 8) ^ 32'(a * 3 + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, a0, act0, ref0, d;
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(dram_ras_n && dram_we_n && dram_cas_n == 4'hF, "R1 strobes", {dram_ras_n, dram_we_n, dram_cas_n}, 6'h3F);
    chk(!req_ready && !rd_valid && !dram_dq_oe, "R1 ready/valid/oe", {req_ready, rd_valid, dram_dq_oe}, 0);
    rst = 1'b0;
    t0 = cyc;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 4'hF && !req_ready, "R1 first cycle", {dram_ras_n, dram_cas_n}, 5'h1F);
    while (!req_ready) @(negedge clk);
    // R2 power-up pause and warm-up
    chk(first_ref_t - t0 >= PWRUP, "R2 pause", first_ref_t - t0, PWRUP);
    chk(ref_cnt == 8, "R2 warm-up refreshes", ref_cnt, 8);
    chk(act_cnt == 0, "R2 no activation", act_cnt, 0);

    // R4 R7 full write sweep then every byte-enable pattern
    for (int a = 0; a < NW; a++) begin
      xfer(1'b1, a, 4'hF, pat(a));
      shadow[a] = pat(a);
    end
    for (int be = 0; be < 16; be++) begin
      int a = (be * 4 + 1) % NW;
      logic [31:0] dv = 32'hFFFF_FFFF ^ (32'(be) * 32'h1111_1111);
      xfer(1'b1, a, be[3:0], dv);
      for (int l = 0; l < 4; l++) if (be[l]) shadow[a][l*8 +: 8] = dv[l*8 +: 8];
    end
    repeat (20) @(negedge clk);
    for (int a = 0; a < NW; a++)
      chk(mem[a] == shadow[a], "R4 R7 array contents", mem[a], shadow[a]);

    // R6 read back
    rd_n = 0;
    for (int a = 0; a < NW; a++) xfer(1'b0, a, 4'hF, 32'h0);
    repeat (20) @(negedge clk);
    chk(rd_n == NW, "R6 read count", rd_n, NW);
    for (int a = 0; a < NW; a++) begin
      chk(rd_log[a] == shadow[a], "R6 read data", rd_log[a], shadow[a]);
      chk(rd_lat[a] == T_CAC, "R6 read latency", rd_lat[a], T_CAC);
    end

    // R8 page hits in one row
    a0 = 5 * NCOL; act0 = act_cnt; ref0 = ref_cnt;
    for (int k = 0; k < 8; k++) xfer(1'b0, a0 + k, 4'hF, 32'h0);
    repeat (20) @(negedge clk);
    chk(act_cnt - act0 == 1 + (ref_cnt - ref0), "R8 page hit activations", act_cnt - act0, 1 + (ref_cnt - ref0));

    // R9 row misses
    act0 = act_cnt;
    for (int k = 0; k < 4; k++) xfer(1'b0, (k % 2) * NCOL, 4'hF, 32'h0);
    repeat (20) @(negedge clk);
    chk(act_cnt - act0 == 4, "R9 miss activations", act_cnt - act0, 4);
    chk(pre_min >= T_RP, "R9 precharge", pre_min, T_RP);

    // R11 long page burst
    act0 = act_cnt;
    for (int k = 0; k < 24; k++) xfer(1'b0, 2 * NCOL + (k % NCOL), 4'hF, 32'h0);
    repeat (20) @(negedge clk);
    chk(act_cnt - act0 >= 2, "R11 burst split", act_cnt - act0, 2);
    chk(span_max <= RAS_LIMIT + T_CAC + T_CP + 2, "R11 row-open span", span_max, RAS_LIMIT + T_CAC + T_CP + 2);

    // R10 refresh rate while idle
    ref0 = ref_cnt;
    repeat (10 * REF_INT) @(negedge clk);
    d = ref_cnt - ref0;
    chk(d >= 9 && d <= 11, "R10 refresh count", d, 10);

    chk(bad_cbr == 0, "R3 refresh form", bad_cbr, 0);
    chk(bad_ew == 0, "R5 early write", bad_ew, 0);
    chk(bad_oe == 0, "R5 read drive off", bad_oe, 0);
    chk(rcd_min >= T_RCD, "R12 row to column delay", rcd_min, T_RCD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule